// File: doc/BRIEF.md
# Preset-Window Modulo Counter

This block is a synchronous binary up counter whose count cycles through a window of values fixed by two parameters, a start value and a terminal value. The counting core has a count enable, a carry-out for cascading and a synchronous parallel load that wins over counting. A wrapper around the core closes the loop. When the count sits on the terminal value with the enable high, the next clock loads the start value rather than incrementing. Reset presets the start value, and never clears to zero. The default settings (start 9, terminal 14) give the period-6 sequence 9, 10, 11, 12, 13, 14, 9, and so on.

Reset is asynchronous and active low. It presets the register at once. A two-stage synchronizer then holds the load path on the start value for two more clock edges after release. An external parallel load lets the surrounding logic place any value in the counter. A value outside the window finds its way back by plain counting. A one-cycle terminal pulse marks the cycle before each wrap reload. When the terminal value is the all-ones code, the carry-out itself drives the reload.

Top module: `lcm_modulo_counter`

## Requirements
- R1: With en low and ld low, count keeps its value across a clock edge.
- R2: With en high, ld low and count not equal to the terminal value, count becomes count+1 modulo 2^WIDTH on the next edge. 15 wraps to 0 in the 4-bit case.
- R3: With ld high, the next edge puts ld_data into count whatever en is. Loading wins over counting and over the terminal reload.
- R4: carry_out is high in exactly those cycles where count is all ones and en is high.
- R5: While rst_n is low, count equals the start value without waiting for a clock. After release, count stays at the start value across the first two clock edges and counts from the third.
- R6: When count equals the terminal value, en is high, ld is low and the reset window is over, term_pulse is high in that cycle and the next edge loads the start value. With the defaults this gives 9..14 repeating with period 6.
- R7: When count equals the terminal value and en is low, term_pulse stays low and count holds.
- R8: A count outside the window rejoins it by counting. A value above the terminal value climbs to all ones, wraps to 0 and climbs to the start value. It reaches the terminal value at most 2^WIDTH edges after leaving.
- R9: With the terminal value equal to all ones (start 3), the reload is taken from carry_out, giving 3..15 repeating.
- R10: With start 0 and terminal 6, the sequence is 0..6 repeating with period 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, presets the start value |
| en | input | 1 | Count enable |
| ld | input | 1 | Parallel load request |
| ld_data | input | WIDTH | Value captured on a load |
| count | output | WIDTH | Present count |
| carry_out | output | 1 | All ones while enabled |
| term_pulse | output | 1 | High in the cycle before a wrap reload |

## Verification
Three configurations run side by side on the same stimulus: the default window, the 0..6 window and a window ending at all ones. A model in the bench predicts every output of every configuration. Every 4-bit value is loaded in turn and then counted onward. This catches a design that leaves the lost states stuck, loses the wrap from 15 to 0, or lets carry_out fire without the enable. Enable toggling at the terminal value shows up a reload that ignores the enable. A pulse that appears during a load also shows up. An asynchronous reset dropped mid-cycle checks the immediate preset, and the two-edge hold after release is timed to the cycle. A design that clears to zero or starts counting early therefore fails.

// File: rtl/lcm_pkg.sv
package lcm_pkg;

  // Operation chosen by the counting core for the coming edge.
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_INC  = 2'd1,
    OP_LOAD = 2'd2
  } cnt_op_e;

  localparam int unsigned LCM_DEF_WIDTH = 4;
  localparam int unsigned LCM_DEF_START = 9;
  localparam int unsigned LCM_DEF_TERM  = 14;
  localparam int unsigned LCM_SYNC_STAGES = 2;

endpackage

// File: rtl/lcm_rst_sync.sv
module lcm_rst_sync #(
  parameter int unsigned STAGES = lcm_pkg::LCM_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_hold
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  // Shift ones in after release; any stage low means the window is still open.
  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_hold = ~sync_q[LAST];

endmodule

// File: rtl/lcm_core.sv
module lcm_core #(
  parameter int unsigned WIDTH  = lcm_pkg::LCM_DEF_WIDTH,
  parameter int unsigned PRESET = lcm_pkg::LCM_DEF_START
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] q,
  output logic             co
);
  import lcm_pkg::*;

  localparam logic [WIDTH-1:0] PRESET_V = WIDTH'(PRESET);

  cnt_op_e          op;
  logic [WIDTH-1:0] tgl;
  logic [WIDTH-1:0] inc_val;
  logic [WIDTH-1:0] q_nxt;
  logic             upd;

  // Per-bit toggle terms: a bit flips when every lower bit is one.
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_tgl
      if (gi == 0) begin : g_lsb
        assign tgl[gi] = 1'b1;
      end else begin : g_upper
        assign tgl[gi] = &q[gi-1:0];
      end
    end
  endgenerate

  assign inc_val = q ^ tgl;

  always_comb begin
    if (load) begin
      op = OP_LOAD;
    end else if (cnt_en) begin
      op = OP_INC;
    end else begin
      op = OP_HOLD;
    end
  end

  always_comb begin
    upd   = 1'b0;
    q_nxt = q;
    case (op)
      OP_LOAD: begin
        upd   = 1'b1;
        q_nxt = load_val;
      end
      OP_INC: begin
        upd   = 1'b1;
        q_nxt = inc_val;
      end
      default: begin
        upd   = 1'b0;
        q_nxt = q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= PRESET_V;
    end else if (upd) begin
      q <= q_nxt;
    end
  end

  assign co = (&q) & cnt_en;

  // R1: idle core keeps its state
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !cnt_en) |=> $stable(q));

  // R2: count step of one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_en) |=> (q == WIDTH'($past(q) + 1'b1)));

  // R3: load captures the data input
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(load_val)));

  // R4: carry without load is followed by the wrap to zero
  a_r4_carry_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (co && !load) |=> (q == '0));

endmodule

// File: rtl/lcm_term_det.sv
module lcm_term_det #(
  parameter int unsigned WIDTH = lcm_pkg::LCM_DEF_WIDTH,
  parameter int unsigned TERM  = lcm_pkg::LCM_DEF_TERM
) (
  input  logic [WIDTH-1:0] q,
  input  logic             cnt_en,
  input  logic             co,
  output logic             hit
);

  localparam logic [WIDTH-1:0] TERM_V = WIDTH'(TERM);
  localparam logic [WIDTH-1:0] ALL1_V = '1;

  generate
    if (TERM_V == ALL1_V) begin : g_from_carry
      // The terminal code is all ones: the carry already flags it.
      logic unused_ok;
      assign unused_ok = ^q;
      assign hit = co;
    end else begin : g_compare
      logic unused_ok;
      assign unused_ok = co;
      assign hit = (q == TERM_V) & cnt_en;
    end
  endgenerate

endmodule

// File: rtl/lcm_modulo_counter.sv
module lcm_modulo_counter #(
  parameter int unsigned WIDTH = lcm_pkg::LCM_DEF_WIDTH,
  parameter int unsigned START = lcm_pkg::LCM_DEF_START,
  parameter int unsigned TERM  = lcm_pkg::LCM_DEF_TERM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_data,
  output logic [WIDTH-1:0] count,
  output logic             carry_out,
  output logic             term_pulse
);

  localparam logic [WIDTH-1:0] START_V = WIDTH'(START);
  localparam logic [WIDTH-1:0] TERM_V  = WIDTH'(TERM);

  generate
    if (TERM < START || TERM >= (1 << WIDTH)) begin : g_bad_cfg
      $error("lcm_modulo_counter: TERM must lie in [START, 2**WIDTH-1]");
    end
  endgenerate

  logic             rst_hold;
  logic             hit;
  logic             core_load;
  logic [WIDTH-1:0] core_val;
  logic             core_co;

  lcm_rst_sync #(
    .STAGES (lcm_pkg::LCM_SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_hold (rst_hold)
  );

  lcm_term_det #(
    .WIDTH (WIDTH),
    .TERM  (TERM)
  ) u_det (
    .q      (count),
    .cnt_en (en),
    .co     (core_co),
    .hit    (hit)
  );

  // Load source priority: reset window, external load, wrap reload.
  always_comb begin
    core_load = rst_hold | ld | hit;
    if (rst_hold) begin
      core_val = START_V;
    end else if (ld) begin
      core_val = ld_data;
    end else begin
      core_val = START_V;
    end
  end

  lcm_core #(
    .WIDTH  (WIDTH),
    .PRESET (START)
  ) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (en),
    .load     (core_load),
    .load_val (core_val),
    .q        (count),
    .co       (core_co)
  );

  assign carry_out  = core_co;
  assign term_pulse = hit & ~ld & ~rst_hold;

  // R6: a terminal pulse is followed by the start value
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |=> (count == START_V));

  // R5: the post-release window keeps the preset
  a_r5_preset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rst_hold |=> (count == START_V));

  // R7: disabled at the terminal value means no pulse and no move
  a_r7_idle_term: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TERM_V && !en && !ld && !rst_hold) |=> (count == TERM_V));

  // R4: carry only while enabled
  a_r4_carry_en: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> en);

endmodule

// File: tb/test_lcm_modulo_counter.sv
module test_lcm_modulo_counter;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 3;
  localparam int ST [NI] = '{9, 0, 3};
  localparam int TM [NI] = '{14, 6, 15};

  logic       clk;
  logic       rst_n;
  logic       en;
  logic       ld;
  logic [3:0] ld_data;
  logic [3:0] cnt [NI];
  logic [NI-1:0] co;
  logic [NI-1:0] tp;

  int errors;
  int checks;
  int rs;
  bit finished;
  logic [3:0] mq [NI];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  lcm_modulo_counter #(.WIDTH(4), .START(9), .TERM(14)) i_lcm_modulo_counter (
    .clk(clk), .rst_n(rst_n), .en(en), .ld(ld), .ld_data(ld_data),
    .count(cnt[0]), .carry_out(co[0]), .term_pulse(tp[0]));

  lcm_modulo_counter #(.WIDTH(4), .START(0), .TERM(6)) i_lcm_modulo_counter_m7 (
    .clk(clk), .rst_n(rst_n), .en(en), .ld(ld), .ld_data(ld_data),
    .count(cnt[1]), .carry_out(co[1]), .term_pulse(tp[1]));

  lcm_modulo_counter #(.WIDTH(4), .START(3), .TERM(15)) i_lcm_modulo_counter_t15 (
    .clk(clk), .rst_n(rst_n), .en(en), .ld(ld), .ld_data(ld_data),
    .count(cnt[2]), .carry_out(co[2]), .term_pulse(tp[2]));

  task automatic chk(input string tag, input string what, input int k,
                     input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s inst%0d actual=%0d expected=%0d at %0t",
               tag, what, k, act, exp, $time);
    end
  endtask

  task automatic preset_model();
    for (int k = 0; k < NI; k++) mq[k] = 4'(ST[k]);
    rs = 0;
  endtask

  // Called just after a falling edge: drive, check outputs, clock, check count.
  task automatic cyc(input string tag, input logic e, input logic l,
                     input logic [3:0] d);
    en = e; ld = l; ld_data = d;
    #1;
    for (int k = 0; k < NI; k++) begin
      chk(tag, "carry_out", k, int'(co[k]), int'(mq[k] == 4'hF && e));
      chk(tag, "term_pulse", k, int'(tp[k]),
          int'(rs >= 2 && !l && e && mq[k] == 4'(TM[k])));
    end
    @(posedge clk);
    for (int k = 0; k < NI; k++) begin
      if (rs < 2) mq[k] = 4'(ST[k]);
      else if (l) mq[k] = d;
      else if (e) mq[k] = (mq[k] == 4'(TM[k])) ? 4'(ST[k]) : 4'(mq[k] + 4'd1);
    end
    if (rs < 2) rs++;
    @(negedge clk);
    for (int k = 0; k < NI; k++) chk(tag, "count", k, int'(cnt[k]), int'(mq[k]));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    errors = 0; checks = 0; finished = 1'b0;
    rst_n = 1'b1; en = 1'b0; ld = 1'b0; ld_data = '0;
    #1 rst_n = 1'b0;
    preset_model();
    #2;
    // R5: preset value during reset, before any clock
    for (int k = 0; k < NI; k++) chk("R5", "count", k, int'(cnt[k]), ST[k]);
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < NI; k++) chk("R5", "count", k, int'(cnt[k]), ST[k]);
    rst_n = 1'b1;
    // R5: two-edge hold, then counting
    for (int i = 0; i < 4; i++) cyc("R5", 1'b1, 1'b0, 4'd0);
    // R6 R9 R10: free-running sequences
    for (int i = 0; i < 45; i++) cyc("R6/R9/R10", 1'b1, 1'b0, 4'd0);
    // R1 R7: enable patterns, including holds at the terminal value
    for (int i = 0; i < 60; i++) cyc("R1/R7", (i % 3) != 0 && (i % 7) != 5, 1'b0, 4'd0);
    // R3 R8 R2 R4: every value loaded, then counted onward
    for (int v = 0; v < 16; v++) begin
      cyc("R3", (v % 2) == 0, 1'b1, 4'(v));
      for (int i = 0; i < 20; i++) cyc("R8/R2/R4", 1'b1, 1'b0, 4'd0);
      cyc("R3", 1'b1, 1'b1, 4'(15 - v));
      cyc("R2/R4", 1'b1, 1'b0, 4'd0);
    end
    // R8: from 15 the default window is regained after the wrap
    cyc("R8", 1'b1, 1'b1, 4'd15);
    for (int i = 0; i < 18; i++) cyc("R8", 1'b1, 1'b0, 4'd0);
    // R5: asynchronous reset asserted mid-cycle
    cyc("R5", 1'b1, 1'b1, 4'd12);
    #1 rst_n = 1'b0;
    preset_model();
    #1;
    for (int k = 0; k < NI; k++) chk("R5", "count", k, int'(cnt[k]), ST[k]);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 25; i++) cyc("R5/R6", 1'b1, 1'b0, 4'd0);
    finish_run();
  end

endmodule